// File: doc/BRIEF.md
# Link Mode and Negotiation Restart Controller

This block sits beside the management register file of a 10/100 Ethernet transceiver. It takes the speed, duplex, negotiation-enable and restart fields of the basic control register, the link status, and the result of the negotiation engine. From these it decides when the data path may carry traffic and when the negotiation engine is told to begin. It also settles which speed and duplex are in force. Carrier sense and collision are derived here from the transmit and receive activity flags, according to the duplex in force.

A restart comes from a write of one to the restart field or from a loss of link while negotiation is enabled. It silences the data path for a break-link interval of `BREAK_CYCLES` clocks. At the end of that interval a one-cycle start pulse goes to the negotiation engine. A further restart during the interval starts the interval over. Coming out of reset counts as a restart.

When negotiation is disabled, the speed and duplex come straight from the control register. When it is enabled, those fields are ignored and the values captured from the negotiation engine are used.

Top module: `link_mode_ctl`

## Requirements
- R1: While reset is held, `restart_bit_o` is 1, `traffic_en_o` is 0, `an_start_o` is 0, and `crs_o` and `col_o` are 0 whatever the activity inputs are. After reset is released, a break-link interval runs.
- R2: A one-cycle `restart_wr_i` pulse makes `restart_bit_o` read 1 from the next cycle. It stays 1 for exactly `BREAK_CYCLES` cycles and then clears by itself.
- R3: In the first cycle after `restart_bit_o` clears, `an_start_o` is 1 for exactly one cycle, provided `an_enable_i` is 1. With `an_enable_i` at 0 no start pulse is issued.
- R4: A restart request during the break interval reloads the timer. `restart_bit_o` then stays 1 for `BREAK_CYCLES` cycles counted from the last request.
- R5: With `an_enable_i` at 1, `link_up_i` falling from 1 to 0 starts a break interval with the same timing as R2.
- R6: `traffic_en_o` is 0 throughout the break interval. With `an_enable_i` at 1 it also stays 0 until `an_done_i` is seen high after the start pulse. A completion seen before the start pulse is not counted.
- R7: With `an_enable_i` at 0, `eff_speed_o` equals `speed_sel_i` and `eff_duplex_o` equals `duplex_sel_i`. `traffic_en_o` is 1 whenever no break is running. Speed 1 means 100 Mb/s and 0 means 10 Mb/s. Duplex 1 means full and 0 means half.
- R8: With `an_enable_i` at 1, `eff_speed_o` and `eff_duplex_o` take the values of `an_speed_i` and `an_duplex_i` captured on the completion that R6 accepts, from the next cycle. `speed_sel_i` and `duplex_sel_i` have no effect.
- R9: In half duplex (effective duplex 0), `crs_o` = `tx_active_i` OR `rx_active_i` and `col_o` = `tx_active_i` AND `rx_active_i`.
- R10: In full duplex (effective duplex 1), `crs_o` = `rx_active_i` and `col_o` is 0.
- R11: During the break interval `crs_o` and `col_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| an_enable_i | input | 1 | Negotiation enable field of the control register |
| speed_sel_i | input | 1 | Forced speed field (1 = 100 Mb/s) |
| duplex_sel_i | input | 1 | Forced duplex field (1 = full) |
| restart_wr_i | input | 1 | One-cycle strobe on a write of 1 to the restart field |
| link_up_i | input | 1 | Link status from the receive side |
| an_done_i | input | 1 | Negotiation engine reports completion |
| an_speed_i | input | 1 | Negotiated speed |
| an_duplex_i | input | 1 | Negotiated duplex |
| tx_active_i | input | 1 | Transmit activity |
| rx_active_i | input | 1 | Receive activity |
| restart_bit_o | output | 1 | Read-back of the restart field, 1 while a restart is pending |
| traffic_en_o | output | 1 | Data path transmit/receive enable |
| an_start_o | output | 1 | One-cycle start pulse to the negotiation engine |
| eff_speed_o | output | 1 | Speed in force |
| eff_duplex_o | output | 1 | Duplex in force |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision |

## Verification
The bench builds the block with `BREAK_CYCLES` set to 8 in place of the roughly 1.2 s default. With that value the full break interval can be counted cycle by cycle: its exact length, the start pulse right after it, and a reload part-way through. The same short interval allows several restarts from a strobe, from link loss and from reset in one short run. Carrier sense and collision are covered by a table of all duplex and activity combinations in forced mode, plus directed checks in negotiated mode.

// File: rtl/link_mode_ctl_pkg.sv
package link_mode_ctl_pkg;

  localparam logic SPEED_10    = 1'b0;
  localparam logic SPEED_100   = 1'b1;
  localparam logic DUPLEX_HALF = 1'b0;
  localparam logic DUPLEX_FULL = 1'b1;

  typedef struct packed {
    logic speed;
    logic duplex;
  } lmc_mode_t;

  localparam lmc_mode_t MODE_DEFAULT = '{speed: SPEED_10, duplex: DUPLEX_HALF};

endpackage

// File: rtl/lmc_rst_sync.sv
module lmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/lmc_restart_seq.sv
// Break-link sequencer: restart detection, timer, start pulse, completion tracking.
module lmc_restart_seq #(
  parameter int BREAK_CYCLES = 30_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_wr_i,
  input  logic link_up_i,
  input  logic an_enable_i,
  input  logic an_done_i,
  output logic break_o,
  output logic an_start_o,
  output logic neg_ok_o,
  output logic accept_o
);

  localparam int TW = (BREAK_CYCLES > 1) ? $clog2(BREAK_CYCLES) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(BREAK_CYCLES - 1);

  logic          break_q, break_d;
  logic [TW-1:0] timer_q, timer_d;
  logic          timer_en;
  logic          start_q, start_d;
  logic          link_q;
  logic          neg_ok_q, neg_ok_d;

  logic link_loss, restart_ev, expire, accept;

  always_comb begin
    link_loss  = link_q & ~link_up_i & an_enable_i;
    restart_ev = restart_wr_i | link_loss;
    expire     = break_q & (timer_q == '0);
    accept     = an_done_i & ~break_q & ~start_q & ~restart_ev;

    break_d = break_q;
    if (restart_ev) begin
      break_d = 1'b1;
    end else if (expire) begin
      break_d = 1'b0;
    end

    timer_en = restart_ev | (break_q & (timer_q != '0));
    timer_d  = restart_ev ? RELOAD : (timer_q - 1'b1);

    start_d = expire & ~restart_ev & an_enable_i;

    neg_ok_d = neg_ok_q;
    if (restart_ev) begin
      neg_ok_d = 1'b0;
    end else if (accept) begin
      neg_ok_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      break_q  <= 1'b1;
      start_q  <= 1'b0;
      link_q   <= 1'b0;
      neg_ok_q <= 1'b0;
    end else begin
      break_q  <= break_d;
      start_q  <= start_d;
      link_q   <= link_up_i;
      neg_ok_q <= neg_ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= RELOAD;
    end else if (timer_en) begin
      timer_q <= timer_d;
    end
  end

  assign break_o    = break_q;
  assign an_start_o = start_q;
  assign neg_ok_o   = neg_ok_q;
  assign accept_o   = accept;

endmodule

// File: rtl/lmc_mode_resolve.sv
// Selects forced or negotiated speed/duplex; holds the negotiated result.
module lmc_mode_resolve
  import link_mode_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept_i,
  input  logic      an_enable_i,
  input  logic      an_speed_i,
  input  logic      an_duplex_i,
  input  logic      speed_sel_i,
  input  logic      duplex_sel_i,
  output lmc_mode_t mode_o
);

  lmc_mode_t neg_q, neg_d;
  lmc_mode_t forced;

  always_comb begin
    neg_d  = '{speed: an_speed_i, duplex: an_duplex_i};
    forced = '{speed: speed_sel_i, duplex: duplex_sel_i};
    mode_o = an_enable_i ? neg_q : forced;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= MODE_DEFAULT;
    end else if (accept_i) begin
      neg_q <= neg_d;
    end
  end

endmodule

// File: rtl/lmc_carrier.sv
// Carrier sense and collision from activity, gated by duplex and break.
module lmc_carrier
  import link_mode_ctl_pkg::*;
(
  input  logic quiet_i,
  input  logic duplex_i,
  input  logic tx_i,
  input  logic rx_i,
  output logic crs_o,
  output logic col_o
);

  logic half;

  always_comb begin
    half  = (duplex_i == DUPLEX_HALF);
    crs_o = ~quiet_i & (rx_i | (half & tx_i));
    col_o = ~quiet_i & half & tx_i & rx_i;
  end

endmodule

// File: rtl/link_mode_ctl.sv
module link_mode_ctl
  import link_mode_ctl_pkg::*;
#(
  parameter int BREAK_CYCLES = 30_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic an_enable_i,
  input  logic speed_sel_i,
  input  logic duplex_sel_i,
  input  logic restart_wr_i,
  input  logic link_up_i,
  input  logic an_done_i,
  input  logic an_speed_i,
  input  logic an_duplex_i,
  input  logic tx_active_i,
  input  logic rx_active_i,
  output logic restart_bit_o,
  output logic traffic_en_o,
  output logic an_start_o,
  output logic eff_speed_o,
  output logic eff_duplex_o,
  output logic crs_o,
  output logic col_o
);

  logic      rst_n_int;
  logic      brk, neg_ok, accept;
  lmc_mode_t mode;

  lmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lmc_restart_seq #(.BREAK_CYCLES(BREAK_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .restart_wr_i (restart_wr_i),
    .link_up_i    (link_up_i),
    .an_enable_i  (an_enable_i),
    .an_done_i    (an_done_i),
    .break_o      (brk),
    .an_start_o   (an_start_o),
    .neg_ok_o     (neg_ok),
    .accept_o     (accept)
  );

  lmc_mode_resolve u_mode (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .accept_i     (accept),
    .an_enable_i  (an_enable_i),
    .an_speed_i   (an_speed_i),
    .an_duplex_i  (an_duplex_i),
    .speed_sel_i  (speed_sel_i),
    .duplex_sel_i (duplex_sel_i),
    .mode_o       (mode)
  );

  lmc_carrier u_crs (
    .quiet_i  (brk),
    .duplex_i (mode.duplex),
    .tx_i     (tx_active_i),
    .rx_i     (rx_active_i),
    .crs_o    (crs_o),
    .col_o    (col_o)
  );

  assign restart_bit_o = brk;
  assign traffic_en_o  = ~brk & (~an_enable_i | neg_ok);
  assign eff_speed_o   = mode.speed;
  assign eff_duplex_o  = mode.duplex;

endmodule

// File: rtl/link_mode_ctl_chk.sv
module link_mode_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic restart_wr_i,
  input logic an_enable_i,
  input logic restart_bit_o,
  input logic traffic_en_o,
  input logic an_start_o,
  input logic eff_duplex_o,
  input logic crs_o,
  input logic col_o
);

  // R6
  break_blocks_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_bit_o |-> !traffic_en_o);

  // R3
  start_after_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    an_start_o |-> ($past(restart_bit_o) && !restart_bit_o));

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    an_start_o |=> !an_start_o);

  // R2
  strobe_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_wr_i |=> restart_bit_o);

  // R10
  full_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_duplex_o |-> !col_o);

  // R11
  break_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_bit_o |-> (!crs_o && !col_o));

  // R9
  col_needs_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_o |-> crs_o);

  // R7
  forced_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!an_enable_i && !restart_bit_o) |-> traffic_en_o);

endmodule

bind link_mode_ctl link_mode_ctl_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .restart_wr_i  (restart_wr_i),
  .an_enable_i   (an_enable_i),
  .restart_bit_o (restart_bit_o),
  .traffic_en_o  (traffic_en_o),
  .an_start_o    (an_start_o),
  .eff_duplex_o  (eff_duplex_o),
  .crs_o         (crs_o),
  .col_o         (col_o)
);

// File: tb/link_mode_ctl_tb_top.sv
module link_mode_ctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BRK = 8;

  // {duplex, speed, tx, rx, exp_crs, exp_col}
  localparam logic [5:0] VEC [8] = '{
    6'b0000_00, 6'b0110_10, 6'b0001_10, 6'b0111_11,
    6'b1000_00, 6'b1110_00, 6'b1001_10, 6'b1111_10
  };

  logic clk = 1'b0;
  logic rst_n;
  logic an_enable_i, speed_sel_i, duplex_sel_i, restart_wr_i, link_up_i;
  logic an_done_i, an_speed_i, an_duplex_i, tx_active_i, rx_active_i;
  logic restart_bit_o, traffic_en_o, an_start_o, eff_speed_o, eff_duplex_o;
  logic crs_o, col_o;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_mode_ctl #(.BREAK_CYCLES(BRK)) dut_i (
    .clk(clk), .rst_n(rst_n), .an_enable_i(an_enable_i), .speed_sel_i(speed_sel_i),
    .duplex_sel_i(duplex_sel_i), .restart_wr_i(restart_wr_i), .link_up_i(link_up_i),
    .an_done_i(an_done_i), .an_speed_i(an_speed_i), .an_duplex_i(an_duplex_i),
    .tx_active_i(tx_active_i), .rx_active_i(rx_active_i), .restart_bit_o(restart_bit_o),
    .traffic_en_o(traffic_en_o), .an_start_o(an_start_o), .eff_speed_o(eff_speed_o),
    .eff_duplex_o(eff_duplex_o), .crs_o(crs_o), .col_o(col_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Count negedges with restart bit high; returns at first negedge with it low.
  task automatic count_break(output int n);
    n = 0;
    while (restart_bit_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic strobe();
    @(negedge clk); restart_wr_i = 1'b1;
    @(negedge clk); restart_wr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0;
    an_enable_i = 1'b0; speed_sel_i = 1'b0; duplex_sel_i = 1'b0; restart_wr_i = 1'b0;
    link_up_i = 1'b1; an_done_i = 1'b0; an_speed_i = 1'b0; an_duplex_i = 1'b0;
    tx_active_i = 1'b1; rx_active_i = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 restart_bit", restart_bit_o, 1);
    check("R1 traffic_en", traffic_en_o, 0);
    check("R1 an_start", an_start_o, 0);
    check("R1 crs", crs_o, 0);
    check("R1 col", col_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 break after reset", restart_bit_o, 1);
    count_break(n);
    // R3 forced mode: no start pulse
    check("R3 no start when disabled", an_start_o, 0);
    tx_active_i = 1'b0; rx_active_i = 1'b0;

    // R7 R9 R10 table in forced mode
    foreach (VEC[i]) begin
      @(negedge clk);
      duplex_sel_i = VEC[i][5]; speed_sel_i = VEC[i][4];
      tx_active_i  = VEC[i][3]; rx_active_i = VEC[i][2];
      #1;
      check(VEC[i][5] ? "R10 crs" : "R9 crs", crs_o, VEC[i][1]);
      check(VEC[i][5] ? "R10 col" : "R9 col", col_o, VEC[i][0]);
      check("R7 speed", eff_speed_o, VEC[i][4]);
      check("R7 duplex", eff_duplex_o, VEC[i][5]);
      check("R7 traffic", traffic_en_o, 1);
    end

    // R2 break length, R11 quiet during break, forced mode
    duplex_sel_i = 1'b0; tx_active_i = 1'b1; rx_active_i = 1'b1;
    strobe();
    check("R11 crs in break", crs_o, 0);
    check("R11 col in break", col_o, 0);
    check("R6 traffic in break", traffic_en_o, 0);
    count_break(n);
    check("R2 break length", n, BRK);
    check("R3 no start when disabled", an_start_o, 0);
    check("R9 col after break", col_o, 1);

    // Negotiated mode
    tx_active_i = 1'b0; rx_active_i = 1'b0;
    an_enable_i = 1'b1;
    strobe();
    count_break(n);
    check("R2 break length AN", n, BRK);
    check("R3 start pulse", an_start_o, 1);
    @(negedge clk);
    check("R3 start one cycle", an_start_o, 0);
    check("R6 traffic before done", traffic_en_o, 0);
    an_done_i = 1'b1; an_speed_i = 1'b1; an_duplex_i = 1'b1;
    speed_sel_i = 1'b0; duplex_sel_i = 1'b0;
    @(negedge clk);
    check("R6 traffic after done", traffic_en_o, 1);
    check("R8 speed", eff_speed_o, 1);
    check("R8 duplex", eff_duplex_o, 1);
    speed_sel_i = 1'b0; duplex_sel_i = 1'b0; tx_active_i = 1'b1; rx_active_i = 1'b1;
    @(negedge clk);
    check("R8 forced bits ignored", eff_duplex_o, 1);
    check("R10 col full AN", col_o, 0);
    tx_active_i = 1'b1; rx_active_i = 1'b0;
    #1;
    check("R10 crs full AN", crs_o, 0);
    tx_active_i = 1'b0;

    // R4 reload during break
    strobe();
    repeat (3) @(negedge clk);
    strobe();
    count_break(n);
    check("R4 reload length", n, BRK);
    check("R3 start after reload", an_start_o, 1);
    @(negedge clk);
    check("R6 stale done ignored", traffic_en_o, 0);
    an_done_i = 1'b0;
    @(negedge clk);
    an_done_i = 1'b1; an_speed_i = 1'b0; an_duplex_i = 1'b0;
    @(negedge clk);
    check("R6 traffic after new done", traffic_en_o, 1);
    check("R8 new duplex", eff_duplex_o, 0);

    // R5 link loss
    an_done_i = 1'b0;
    link_up_i = 1'b0;
    @(negedge clk);
    check("R5 link loss restart", restart_bit_o, 1);
    count_break(n);
    check("R5 break length", n, BRK);
    check("R5 start pulse", an_start_o, 1);
    link_up_i = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule